// File: doc/BRIEF.md
# Overcurrent Fault Response Controller

This block watches one overcurrent flag per supply rail and turns each qualified fault into one of three actions. The action is chosen per rail by software. The first action raises an interrupt and leaves the processor running. The second drops the power-hold output so that the processor loses power and later cold starts. The third sends a fixed-length warm-reset pulse to the processor while power stays on. The warm-reset path raises no interrupt, so software cannot intercept it.

Each fault flag passes through a two-flop synchronizer. A fault acts only after it has stayed high for a programmable number of consecutive cycles. Each time a flag is asserted it produces at most one action. When several rails fault in the same cycle, a fixed priority picks one action. A warm reset leaves a bit-coded reason word that the reset it caused does not clear. Software reads this word after reboot and clears it by writing ones to its bits.

Registers sit behind a simple port. A write takes effect at the clock edge where `reg_wr` is high. A read returns data combinationally from `reg_addr`. These are the addresses:
- 0 holds the per-rail response codes.
- 1 holds the qualification threshold.
- 2 holds the interrupt status, cleared by writing 1.
- 3 holds the interrupt mask.
- 4 holds the warm-reset reason, cleared by writing 1.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: A rail fault takes effect only after its synchronized flag has been high for T consecutive cycles. T is the threshold at address 1, and a value of 0 counts as 1. With threshold T, the action becomes visible at the outputs T+2 clock edges after the flag rises. A flag held for fewer than T cycles has no effect.
- R2: Rail i takes its response code from bits [2i+1:2i] of address 0. Code 00 means interrupt only, 01 means warm reset, 10 means shutdown, and 11 behaves as interrupt only.
- R3: An interrupt-only fault on rail i sets bit i of the status register at address 2. `irq` is high while any status bit is set and its bit in the mask register (address 3, 1 = masked) is clear. Writing 1 to a status bit clears it.
- R4: A shutdown fault drives `pwr_hold` low. It stays low until `rst_n` is asserted, and while it is low no further warm-reset pulse or interrupt status is produced.
- R5: A warm-reset fault produces a `wrst_pulse` that is high for exactly 16 cycles and sets no interrupt status bit.
- R6: A warm reset sets bit 0 of the reason register at address 4 and bit 8+i for the faulting rail i. These bits stay set after the pulse ends. They are cleared only by writing 1 to them or by `rst_n`.
- R7: A warm-reset fault that qualifies while a pulse is active neither restarts nor extends that pulse, but its reason bit is still set.
- R8: When several rails qualify in the same cycle, shutdown overrides warm reset and warm reset overrides interrupt only. The losing actions leave no trace.
- R9: A fault flag held high acts once. It acts again only after it has gone low and qualified anew.
- R10: After reset, `pwr_hold` is 1, `irq` and `wrst_pulse` are 0, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (cold start) |
| rail_fault | input | N_RAILS | Asynchronous overcurrent flag, one per rail |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt, high while an unmasked status bit is set |
| pwr_hold | output | 1 | Power-hold, driven low on a shutdown fault |
| wrst_pulse | output | 1 | Warm-reset pulse to the processor |

## Verification
The hardest situation to reach is a second warm-reset fault arriving while a pulse is already running. Sampling the pulse from its first high cycle cannot show whether it was extended. The bench waits until the pulse is seen high, then raises a second warm-reset rail at once. That rail qualifies three edges later, well inside the 16-cycle window. The bench counts every remaining high cycle and checks the total and the second rail's reason bit. Same-cycle priority is reached by raising the flags of differently configured rails on the same falling edge, so that all of them qualify together.

// File: rtl/ocp_fault_ctrl.sv
`timescale 1ns/1ps
module ocp_fault_ctrl #(
  parameter int N_RAILS   = 4,
  parameter int DEB_W     = 4,
  parameter int PULSE_LEN = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] rail_fault,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq,
  output logic               pwr_hold,
  output logic               wrst_pulse
);
  localparam int PCNT_W  = $clog2(PULSE_LEN + 1);
  localparam int RSN_LSB = 8;
  localparam logic [ADDR_W-1:0] A_RESP = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DEB  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RSN  = ADDR_W'(4);

  logic [2*N_RAILS-1:0] resp_cfg;
  logic [DEB_W-1:0]     deb_thr, thr_eff;
  logic [N_RAILS-1:0]   irq_stat, irq_mask, rsn_rail;
  logic                 rsn_any;
  logic [N_RAILS-1:0]   sync1, sync2, fire;
  logic [N_RAILS-1:0]   sel_shut, sel_warm, sel_irq;
  logic [PCNT_W-1:0]    pcnt;
  logic                 any_shut, any_warm, act_warm;
  logic [N_RAILS-1:0]   act_irq;
  logic                 wr_resp, wr_deb, wr_stat, wr_mask, wr_rsn;
  logic                 unused_wdata;

  assign thr_eff = (deb_thr == '0) ? DEB_W'(1) : deb_thr;
  assign wr_resp = reg_wr && reg_addr == A_RESP;
  assign wr_deb  = reg_wr && reg_addr == A_DEB;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign wr_mask = reg_wr && reg_addr == A_MASK;
  assign wr_rsn  = reg_wr && reg_addr == A_RSN;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= rail_fault;
      sync2 <= sync1;
    end

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    logic [DEB_W-1:0] cnt;
    logic [1:0]       code;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          cnt <= '0;
      else if (!sync2[i])  cnt <= '0;
      else if (cnt < thr_eff) cnt <= cnt + DEB_W'(1);
    assign fire[i]     = sync2[i] && (cnt == thr_eff - DEB_W'(1));
    assign code        = resp_cfg[2*i +: 2];
    assign sel_shut[i] = fire[i] && code == 2'b10;
    assign sel_warm[i] = fire[i] && code == 2'b01;
    assign sel_irq[i]  = fire[i] && (code == 2'b00 || code == 2'b11);
  end

  assign any_shut = pwr_hold && |sel_shut;
  assign any_warm = pwr_hold && |sel_warm;
  assign act_warm = any_warm && !any_shut;
  assign act_irq  = sel_irq & {N_RAILS{pwr_hold && !any_shut && !any_warm}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      resp_cfg <= '0;
      deb_thr  <= '0;
      irq_mask <= '0;
    end else begin
      if (wr_resp) resp_cfg <= reg_wdata[2*N_RAILS-1:0];
      if (wr_deb)  deb_thr  <= reg_wdata[DEB_W-1:0];
      if (wr_mask) irq_mask <= reg_wdata[N_RAILS-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_stat <= '0;
    else        irq_stat <= (irq_stat & ~(reg_wdata[N_RAILS-1:0] & {N_RAILS{wr_stat}})) | act_irq;

  assign irq = |(irq_stat & ~irq_mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pwr_hold <= 1'b1;
    else if (any_shut) pwr_hold <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             pcnt <= '0;
    else if (pcnt != '0)    pcnt <= pcnt - PCNT_W'(1);
    else if (act_warm)      pcnt <= PCNT_W'(PULSE_LEN);

  assign wrst_pulse = pcnt != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsn_any  <= 1'b0;
      rsn_rail <= '0;
    end else begin
      rsn_any  <= (rsn_any & ~(wr_rsn & reg_wdata[0])) | act_warm;
      rsn_rail <= (rsn_rail & ~(reg_wdata[RSN_LSB +: N_RAILS] & {N_RAILS{wr_rsn}}))
                | (sel_warm & {N_RAILS{act_warm}});
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RESP: reg_rdata[2*N_RAILS-1:0] = resp_cfg;
      A_DEB:  reg_rdata[DEB_W-1:0]     = deb_thr;
      A_STAT: reg_rdata[N_RAILS-1:0]   = irq_stat;
      A_MASK: reg_rdata[N_RAILS-1:0]   = irq_mask;
      A_RSN: begin
        reg_rdata[0]                   = rsn_any;
        reg_rdata[RSN_LSB +: N_RAILS]  = rsn_rail;
      end
      default: reg_rdata = '0;
    endcase
  end

  logic [PCNT_W:0] chk_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          chk_len <= '0;
    else if (wrst_pulse) chk_len <= chk_len + 1'b1;
    else                 chk_len <= '0;

  AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !pwr_hold |=> !pwr_hold); // R4
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n) wrst_pulse |-> chk_len < (PCNT_W+1)'(PULSE_LEN)); // R7
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(wrst_pulse) |-> chk_len == (PCNT_W+1)'(PULSE_LEN)); // R5
  AST_REASON_SET: assert property (@(posedge clk) disable iff (!rst_n) $rose(wrst_pulse) |-> rsn_any); // R6
  AST_WARM_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n) act_warm |=> (irq_stat & ~$past(irq_stat)) == '0); // R5
  AST_SHUT_WINS: assert property (@(posedge clk) disable iff (!rst_n) !pwr_hold |-> !$rose(wrst_pulse)); // R8
endmodule

// File: tb/ocp_fault_ctrl_bench.sv
`timescale 1ns/1ps
module ocp_fault_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rail_fault = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, pwr_hold, wrst_pulse;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  ocp_fault_ctrl u_ocp_fault_ctrl (
    .clk(clk), .rst_n(rst_n), .rail_fault(rail_fault), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .pwr_hold(pwr_hold), .wrst_pulse(wrst_pulse));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rail_fault = '0; reg_wr = 1'b0;
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
  endtask

  task automatic pulse_len(output int n);
    n = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (wrst_pulse) n++; else break;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    check("R10 pwr_hold", pwr_hold, 1);
    check("R10 irq", irq, 0);
    check("R10 wrst_pulse", wrst_pulse, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R10 register", d, 0);
    end
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(3'd1, 16'd0);
    rail_fault[0] = 1'b1;
    waitn(2);
    check("R1 irq before T+2 edges", irq, 0);
    waitn(1);
    check("R3 irq after fault", irq, 1);
    rd(3'd2, d);
    check("R3 status bit0", d, 16'h0001);
    wr(3'd3, 16'h0001);
    check("R3 masked irq", irq, 0);
    wr(3'd3, 16'h0000);
    check("R3 unmasked irq", irq, 1);
    wr(3'd2, 16'h0001);
    check("R3 W1C irq", irq, 0);
    waitn(10);
    rd(3'd2, d);
    check("R9 held fault acts once", d, 0);
    rail_fault[0] = 1'b0;
    waitn(5);
    rail_fault[0] = 1'b1;
    waitn(3);
    rd(3'd2, d);
    check("R9 re-qualified fault acts", d, 16'h0001);
    rail_fault[0] = 1'b0;
    wr(3'd2, 16'h000f);
    waitn(4);
  endtask

  task automatic t_debounce();
    logic [15:0] d;
    wr(3'd1, 16'd4);
    rail_fault[1] = 1'b1;
    waitn(3);
    rail_fault[1] = 1'b0;
    waitn(10);
    rd(3'd2, d);
    check("R1 short fault ignored", d, 0);
    rail_fault[1] = 1'b1;
    waitn(5);
    rd(3'd2, d);
    check("R1 not yet at T+1 edges", d, 0);
    waitn(1);
    rd(3'd2, d);
    check("R1 acts at T+2 edges", d, 16'h0002);
    rail_fault[1] = 1'b0;
    wr(3'd2, 16'h000f);
    wr(3'd1, 16'd0);
    waitn(4);
  endtask

  task automatic t_warm();
    logic [15:0] d;
    int n;
    wr(3'd0, 16'h0010);
    rail_fault[2] = 1'b1;
    waitn(2);
    check("R5 no pulse yet", wrst_pulse, 0);
    waitn(1);
    check("R5 pulse starts", wrst_pulse, 1);
    pulse_len(n);
    check("R5 pulse length 16", n, 16);
    check("R5 no irq on warm", irq, 0);
    rd(3'd2, d);
    check("R5 no status on warm", d, 0);
    check("R5 power held", pwr_hold, 1);
    rd(3'd4, d);
    check("R6 reason after pulse", d, 16'h0401);
    rail_fault[2] = 1'b0;
    wr(3'd4, 16'h0401);
    rd(3'd4, d);
    check("R6 reason W1C", d, 0);
    waitn(4);
  endtask

  task automatic t_no_extend();
    logic [15:0] d;
    int n;
    wr(3'd0, 16'h0050);
    rail_fault[2] = 1'b1;
    waitn(3);
    check("R7 first pulse up", wrst_pulse, 1);
    rail_fault[3] = 1'b1;
    pulse_len(n);
    check("R7 pulse not extended", n, 16);
    rd(3'd4, d);
    check("R7 second rail reason", d, 16'h0c01);
    rail_fault = '0;
    wr(3'd4, 16'hffff);
    waitn(4);
  endtask

  task automatic t_warm_over_irq();
    logic [15:0] d;
    int n;
    wr(3'd0, 16'h0004);
    rail_fault[1] = 1'b1; rail_fault[2] = 1'b1;
    waitn(3);
    check("R8 warm wins pulse", wrst_pulse, 1);
    rd(3'd2, d);
    check("R8 irq status suppressed", d, 0);
    pulse_len(n);
    rd(3'd4, d);
    check("R2 rail1 code 01 reason", d, 16'h0201);
    rail_fault = '0;
    wr(3'd4, 16'hffff);
    waitn(4);
  endtask

  task automatic t_shutdown();
    logic [15:0] d;
    wr(3'd0, 16'h0006);
    rail_fault[2:0] = 3'b111;
    waitn(2);
    check("R4 power still held", pwr_hold, 1);
    waitn(1);
    check("R4 pwr_hold low", pwr_hold, 0);
    check("R8 shutdown blocks warm", wrst_pulse, 0);
    rd(3'd2, d);
    check("R8 shutdown blocks irq", d, 0);
    rd(3'd4, d);
    check("R8 no reason on shutdown", d, 0);
    rail_fault = '0;
    waitn(5);
    rail_fault[1] = 1'b1;
    waitn(6);
    check("R4 no pulse after shutdown", wrst_pulse, 0);
    check("R4 stays low", pwr_hold, 0);
    do_reset();
    check("R4 released by reset", pwr_hold, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_irq();
    t_debounce();
    t_warm();
    t_no_extend();
    t_warm_over_irq();
    t_shutdown();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule